// File: doc/BRIEF.md
# Symmetric Integrating Delay Filter

This block cleans up a single-bit level signal. The output follows the input only after the input has held its new level for a programmable number of clock ticks. A short excursion to the opposite level does not clear the filter's memory. Instead, an up/down counter absorbs it. The counter is centred on the threshold, so the output stays put unless the input genuinely persists.

Each clock edge is one tick. The block watches the raw input, its own filtered output and a one-tick edge pulse derived from the input, and picks one counter action each tick:

- hold;
- step up;
- step down;
- reload to zero on a qualifying rise;
- reload to twice the delay on a qualifying fall.

The output is a plain comparison of the registered count against the delay value. Changing the delay at run time therefore affects the output at once.

The block has no stream data path. Input, delay and output are plain level pins without valid/ready, so there is no back-pressure to honour: a new input level is taken on every clock edge.

Top module: `integ_delay_filter`

## Requirements
- R1: While and after asynchronous active-low reset, the count is 0, so with a nonzero delay the output is 0.
- R2: After a clean change of input from 0 to 1 with the output low and the count at 0, the output rises on the (D+1)th rising clock edge that samples the new level, where D is the delay value.
- R3: After a clean change of input from 1 to 0 with the output high, the output falls on the (D+2)th rising clock edge that samples the new level.
- R4: For D of at least 2, an input pulse to the opposite level lasting a single tick, followed by a return to the output's level, never changes the output.
- R5: The counter saturates: a step down at a count of 0 leaves the count at 0.
- R6: When the delay value is 0, the output is 1.
- R7: When there is no input edge and the input equals the output, the count holds, so with an unchanged delay the output is unchanged on the next edge.
- R8: The output is 1 exactly when the count is greater than or equal to the current delay value. Lowering the delay below the count raises the output in the same cycle, with no clock edge needed.
- R9: With no edge, the counter steps up when the input is 1 and the output is 0, and steps down when the input is 0 and the output is 1. On an edge, it reloads 0 (input 1, output 0) or twice the delay (input 0, output 1). An edge with input 0 and output 0 steps up; an edge with input 1 and output 1 steps down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every rising edge is one filter tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| delay_i | input | DW | Delay threshold in ticks, may change at any time |
| din_i | input | 1 | Raw input level, already synchronous to clk |
| dout_o | output | 1 | Filtered output level |

## Verification
A wrong count has no direct port of its own. It appears at the output only when it places the comparison on the wrong side of the threshold. A corrupted reload therefore surfaces as an output edge that arrives some ticks too early or too late, up to about D ticks after the fault. A mis-decoded action can stay hidden until the next persistent input change.

The bench therefore compares the output on every cycle against a behavioural model, under random jitter and changing delays. It also measures exact rise and fall latencies, because an off-by-one in a reload or a comparison shows up only there.

// File: rtl/dfilt_pkg.sv
package dfilt_pkg;
  // one counter action is chosen per tick
  typedef enum logic [2:0] {
    ACT_HOLD    = 3'd0,
    ACT_UP      = 3'd1,
    ACT_DOWN    = 3'd2,
    ACT_LOAD_LO = 3'd3,
    ACT_LOAD_HI = 3'd4
  } cnt_act_e;
endpackage

// File: rtl/dfilt_edge.sv
module dfilt_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic chg_o
);
  logic last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= lvl_i;
  end

  assign chg_o = lvl_i ^ last_q;
endmodule

// File: rtl/dfilt_ctrl.sv
module dfilt_ctrl
  import dfilt_pkg::*;
(
  input  logic     lvl_i,
  input  logic     chg_i,
  input  logic     filt_i,
  output cnt_act_e act_o
);
  always_comb begin
    act_o = ACT_HOLD;
    unique case ({chg_i, lvl_i, filt_i})
      3'b000: act_o = ACT_HOLD;
      3'b011: act_o = ACT_HOLD;
      3'b010: act_o = ACT_UP;
      3'b001: act_o = ACT_DOWN;
      3'b110: act_o = ACT_LOAD_LO;
      3'b101: act_o = ACT_LOAD_HI;
      3'b100: act_o = ACT_UP;    // jitter while low
      3'b111: act_o = ACT_DOWN;  // jitter while high
      default: act_o = ACT_HOLD;
    endcase
  end
endmodule

// File: rtl/dfilt_count.sv
module dfilt_count
  import dfilt_pkg::*;
#(
  parameter int DW = 8,
  localparam int CW = DW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cnt_act_e      act_i,
  input  logic [DW-1:0] delay_i,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    case (act_i)
      ACT_UP:      cnt_d = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
      ACT_DOWN:    cnt_d = (cnt_q == '0) ? cnt_q : cnt_q - 1'b1;
      ACT_LOAD_LO: cnt_d = '0;
      ACT_LOAD_HI: cnt_d = {delay_i, 1'b0};
      default:     cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R9
  load_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i == ACT_LOAD_LO) |=> (cnt_q == '0));
  // R9
  load_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i == ACT_LOAD_HI) |=> (cnt_q == {$past(delay_i), 1'b0}));
  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i == ACT_DOWN && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/integ_delay_filter.sv
module integ_delay_filter
  import dfilt_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] delay_i,
  input  logic          din_i,
  output logic          dout_o
);
  localparam int CW = DW + 1;

  logic          chg;
  cnt_act_e      act;
  logic [CW-1:0] cnt;

  dfilt_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_i (din_i),
    .chg_o (chg)
  );

  dfilt_ctrl u_ctrl (
    .lvl_i  (din_i),
    .chg_i  (chg),
    .filt_i (dout_o),
    .act_o  (act)
  );

  dfilt_count #(.DW(DW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .act_i   (act),
    .delay_i (delay_i),
    .cnt_o   (cnt)
  );

  assign dout_o = (cnt >= {1'b0, delay_i});

  // R6
  zero_delay_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (delay_i == '0) |-> dout_o);
  // R7
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chg && din_i == dout_o) |=> (!$stable(delay_i) || $stable(dout_o)));
endmodule

// File: tb/integ_delay_filter_test.sv
`timescale 1ns/1ps
module integ_delay_filter_test;
  localparam int DW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] delay = 6'd5;
  logic          din = 1'b0;
  logic          dout;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  integ_delay_filter #(.DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .delay_i(delay), .din_i(din), .dout_o(dout)
  );

  always #5 clk = ~clk;

  // behavioural reference, one update per tick
  int  m_cnt = 0;
  bit  m_prev = 0;
  string cur_req = "R9";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_prev = 0;
    end else begin
      bit o, e;
      o = (m_cnt >= int'(delay));
      e = (din != m_prev);
      if (!e) begin
        if (din && !o) m_cnt = m_cnt + 1;
        else if (!din && o) m_cnt = (m_cnt > 0) ? m_cnt - 1 : 0;
      end else begin
        if (din && !o) m_cnt = 0;
        else if (!din && o) m_cnt = 2 * int'(delay);
        else if (!din && !o) m_cnt = m_cnt + 1;
        else m_cnt = (m_cnt > 0) ? m_cnt - 1 : 0;
      end
      m_prev = din;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      bit e;
      e = (m_cnt >= int'(delay));
      chk(dout === e, cur_req, int'(dout), int'(e));
    end
  end

  task automatic latency(input logic v, output int n);
    @(negedge clk); din = v; n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk); #2;
    end while (dout !== v && n < 300);
  endtask

  task automatic settle(input int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    int n;
    bit moved;
    repeat (3) @(negedge clk);
    #2;
    // R1: reset state
    chk(dout === 1'b0, "R1", int'(dout), 0);
    @(negedge clk); rst_n = 1'b1;
    #2;
    chk(dout === 1'b0, "R1", int'(dout), 0);
    settle(3);

    // R2 / R3 with D=5 and D=3
    cur_req = "R2"; latency(1'b1, n); chk(n == 6, "R2", n, 6);
    settle(4);
    cur_req = "R3"; latency(1'b0, n); chk(n == 7, "R3", n, 7);
    settle(4);
    delay = 6'd3; settle(2);
    cur_req = "R2"; latency(1'b1, n); chk(n == 4, "R2", n, 4);
    settle(4);
    cur_req = "R3"; latency(1'b0, n); chk(n == 5, "R3", n, 5);
    settle(4);

    // R4: single-tick pulses never toggle output, D=4
    cur_req = "R4";
    delay = 6'd4; settle(2);
    moved = 0;
    for (int p = 0; p < 5; p++) begin
      @(negedge clk); din = 1'b1;
      @(negedge clk); din = 1'b0;
      for (int k = 0; k < 8; k++) begin @(negedge clk); #2; if (dout !== 1'b0) moved = 1; end
    end
    chk(!moved, "R4", int'(moved), 0);
    latency(1'b1, n); settle(6);
    moved = 0;
    for (int p = 0; p < 5; p++) begin
      @(negedge clk); din = 1'b0;
      @(negedge clk); din = 1'b1;
      for (int k = 0; k < 8; k++) begin @(negedge clk); #2; if (dout !== 1'b1) moved = 1; end
    end
    chk(!moved, "R4", int'(moved), 0);

    // R6: zero delay forces output high, R5 saturation under downward steps
    cur_req = "R6";
    @(negedge clk); delay = 6'd0; #2;
    chk(dout === 1'b1, "R6", int'(dout), 1);
    cur_req = "R5";
    @(negedge clk); din = 1'b0;
    settle(40); #2;
    chk(dout === 1'b1, "R5", int'(dout), 1);
    @(negedge clk); delay = 6'd1; #2;
    chk(dout === 1'b0, "R5", int'(dout), 0);

    // R7: quiet input keeps output
    cur_req = "R7";
    settle(10); #2;
    chk(dout === 1'b0, "R7", int'(dout), 0);

    // R8: lowering delay below the count raises output at once
    cur_req = "R8";
    @(negedge clk); delay = 6'd20; din = 1'b0; settle(4);
    @(negedge clk); din = 1'b1;
    settle(6); #2;
    chk(dout === 1'b0, "R8", int'(dout), 0);
    @(negedge clk); delay = 6'd2; #1;
    chk(dout === 1'b1, "R8", int'(dout), 1);

    // R9: random jitter with changing delays, compared every cycle
    cur_req = "R9";
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      if (($urandom % 8) == 0) din = ~din;
      if (c % 500 == 0) delay = DW'($urandom % 7);
      if (c % 1000 == 999) begin din = ~din; settle(20); end
    end
    settle(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule